// File: doc/BRIEF.md
# Continuous Entropy Health Monitor

This block watches the sample stream coming out of a noise source, one sample per cycle when its valid strobe is high. It runs two continuous health tests side by side. The run test counts how many identical samples have arrived in a row. The window test takes the first sample of each fixed-length window as a reference and counts how often that reference comes back within the window. Each test has its own cutoff and its own severity bit. A hit on a non-fatal test gives a one-cycle alarm pulse. A hit on a fatal test moves the block into a dead state that holds until reset.

The only state is three counters: run length, window position and match count, plus the last sample and the reference sample. None of it is visible outside the block. Each window ends after `WIN_LEN` accepted samples, and `WIN_LEN` is limited to 1024, so the state is always flushed within a bounded number of samples. Reset clears every counter.

The run test has two states. REP_EMPTY means no run is open. A new run opens from REP_EMPTY into REP_TRACK when a sample arrives. A hit sends REP_TRACK back to REP_EMPTY. The window test has two states. WIN_CAPTURE means it is waiting for the reference sample. Storing the reference moves it into WIN_COUNT. The last sample of a window moves WIN_COUNT back to WIN_CAPTURE. The supervisor has two states, MON_LIVE and MON_DEAD. It moves from MON_LIVE to MON_DEAD on any hit from a test whose severity bit is set. There is no transition out of MON_DEAD except reset.

Top module: `ehm_health_monitor`

## Requirements
- R1: While reset is low, and after it is released, `alarm_o` and `fail_o` are low. The first accepted sample after reset opens a new run and a new window.
- R2: A sample is accepted only in a cycle where `smp_valid` is 1 and the block is live. Cycles with `smp_valid` at 0 change no test state, whatever `smp_data` holds.
- R3: The run length counts consecutive accepted samples that are equal. An accepted sample that differs from the previous one restarts the run length at 1. The run test hits on the accepted sample that brings the run length to `rep_cutoff`.
- R4: After a run-test hit the run is closed. A further hit needs another `rep_cutoff` equal accepted samples, counted from the next accepted sample.
- R5: A window spans `WIN_LEN` accepted samples. Its first sample becomes the reference and counts as match 1. The accepted sample after a window's last one starts a new window with a new reference. Match counts never carry over between windows.
- R6: The window test hits on the accepted sample equal to the reference that brings the match count to `prop_cutoff`. It hits at most once per window.
- R7: A hit from a test whose severity input (`rep_is_fatal` / `prop_is_fatal`) is 0 makes `alarm_o` go high. It rises at the clock edge that accepts the sample and stays high for exactly one cycle unless the next accepted sample hits again.
- R8: A hit from a test whose severity input is 1 makes `fail_o` go high at the clock edge that accepts the sample. `fail_o` then stays high until reset. While `fail_o` is high, and in the cycle it rises, `alarm_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; zeroizes all counters |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | SAMPLE_W | Noise sample |
| rep_cutoff | input | $clog2(WIN_LEN)+1 | Run length that triggers the run test |
| rep_is_fatal | input | 1 | 1: run-test hit is fatal; 0: alarm |
| prop_cutoff | input | $clog2(WIN_LEN)+1 | Match count that triggers the window test |
| prop_is_fatal | input | 1 | 1: window-test hit is fatal; 0: alarm |
| alarm_o | output | 1 | One-cycle non-fatal alarm pulse |
| fail_o | output | 1 | Sticky fatal failure |

## Verification
Both results are registered at the clock edge that accepts the hitting sample. `alarm_o` is high for the cycle that follows that edge and falls at the next edge. `fail_o` rises at that same edge and then stays high. The bench drives each sample half a period before the edge and reads both outputs one time unit after it. It reads `alarm_o` again one cycle later to confirm the pulse has ended. Each scenario starts from a fresh reset, so the run and window positions it expects always count from the first accepted sample.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
    typedef enum logic {REP_EMPTY, REP_TRACK} rep_state_t;
    typedef enum logic {WIN_CAPTURE, WIN_COUNT} win_state_t;
    typedef enum logic {MON_LIVE, MON_DEAD} mon_state_t;
endpackage

// File: rtl/ehm_rep_test.sv
module ehm_rep_test
    import ehm_pkg::*;
#(
    parameter int SAMPLE_W = 4,
    parameter int CNT_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CNT_W-1:0]    cutoff,
    output logic                hit
);
    rep_state_t          state_q;
    logic [SAMPLE_W-1:0] last_q;
    logic [CNT_W-1:0]    run_q;
    logic [CNT_W-1:0]    run_next;

    // Length of the run including the sample offered this cycle
    always_comb begin
        unique case (state_q)
            REP_EMPTY: run_next = CNT_W'(1);
            REP_TRACK: run_next = (sample == last_q) ? run_q + CNT_W'(1) : CNT_W'(1);
            default:   run_next = CNT_W'(1);
        endcase
        hit = en && (run_next >= cutoff);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= REP_EMPTY;
            last_q  <= '0;
            run_q   <= '0;
        end else if (en) begin
            if (hit) begin
                // close the run: the next sample opens a fresh one
                state_q <= REP_EMPTY;
                last_q  <= '0;
                run_q   <= '0;
            end else begin
                state_q <= REP_TRACK;
                last_q  <= sample;
                run_q   <= run_next;
            end
        end
    end

    // R3: an open run always holds at least one sample
    a_r3_track_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == REP_TRACK) |-> (run_q != '0));
    // R2: no accepted sample, no change of run state
    a_r2_rep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(run_q) && $stable(last_q)));
endmodule

// File: rtl/ehm_prop_test.sv
module ehm_prop_test
    import ehm_pkg::*;
#(
    parameter int SAMPLE_W = 4,
    parameter int WIN_LEN  = 512,
    parameter int CNT_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [CNT_W-1:0]    cutoff,
    output logic                hit
);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN_LEN - 1);

    win_state_t          state_q;
    logic [SAMPLE_W-1:0] ref_q;
    logic [CNT_W-1:0]    pos_q;
    logic [CNT_W-1:0]    match_q;
    logic                is_match;
    logic [CNT_W-1:0]    match_next;

    always_comb begin
        is_match   = (sample == ref_q);
        match_next = match_q + (is_match ? CNT_W'(1) : CNT_W'(0));
        unique case (state_q)
            WIN_CAPTURE: hit = 1'b0;
            WIN_COUNT:   hit = en && is_match && (match_next == cutoff);
            default:     hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WIN_CAPTURE;
            ref_q   <= '0;
            pos_q   <= '0;
            match_q <= '0;
        end else if (en) begin
            unique case (state_q)
                WIN_CAPTURE: begin
                    state_q <= WIN_COUNT;
                    ref_q   <= sample;
                    pos_q   <= CNT_W'(1);
                    match_q <= CNT_W'(1);
                end
                WIN_COUNT: begin
                    if (pos_q == LAST_POS) begin
                        // window complete: flush everything
                        state_q <= WIN_CAPTURE;
                        ref_q   <= '0;
                        pos_q   <= '0;
                        match_q <= '0;
                    end else begin
                        pos_q   <= pos_q + CNT_W'(1);
                        match_q <= match_next;
                    end
                end
                default: state_q <= WIN_CAPTURE;
            endcase
        end
    end

    // R5: position never runs past the window
    a_r5_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q < CNT_W'(WIN_LEN));
    // R6: matches can never outnumber samples seen in the window
    a_r6_match_le_pos: assert property (@(posedge clk) disable iff (!rst_n)
        match_q <= pos_q);
    // R2: no accepted sample, no change of window state
    a_r2_win_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(pos_q) && $stable(match_q) && $stable(ref_q)));
endmodule

// File: rtl/ehm_health_monitor.sv
module ehm_health_monitor
    import ehm_pkg::*;
#(
    parameter int SAMPLE_W = 4,
    parameter int WIN_LEN  = 512,
    localparam int CNT_W   = $clog2(WIN_LEN) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [CNT_W-1:0]    rep_cutoff,
    input  logic                rep_is_fatal,
    input  logic [CNT_W-1:0]    prop_cutoff,
    input  logic                prop_is_fatal,
    output logic                alarm_o,
    output logic                fail_o
);
    mon_state_t state_q, state_d;
    logic       accept;
    logic       rep_hit, prop_hit;
    logic       fatal_hit, soft_hit;

    assign accept = smp_valid && (state_q == MON_LIVE);

    ehm_rep_test #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) i_rep (
        .clk(clk), .rst_n(rst_n), .en(accept), .sample(smp_data),
        .cutoff(rep_cutoff), .hit(rep_hit));

    ehm_prop_test #(.SAMPLE_W(SAMPLE_W), .WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) i_prop (
        .clk(clk), .rst_n(rst_n), .en(accept), .sample(smp_data),
        .cutoff(prop_cutoff), .hit(prop_hit));

    always_comb begin
        fatal_hit = (rep_hit && rep_is_fatal) || (prop_hit && prop_is_fatal);
        soft_hit  = (rep_hit && !rep_is_fatal) || (prop_hit && !prop_is_fatal);
        state_d   = state_q;
        unique case (state_q)
            MON_LIVE: if (fatal_hit) state_d = MON_DEAD;
            MON_DEAD: state_d = MON_DEAD;
            default:  state_d = MON_DEAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_LIVE;
        else        state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_o <= 1'b0;
        end else begin
            alarm_o <= (state_q == MON_LIVE) && soft_hit && !fatal_hit;
        end
    end
    assign fail_o = (state_q == MON_DEAD);

    // R8: failure holds until reset
    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> fail_o);
    // R8: no alarm while failed
    a_r8_no_alarm_dead: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !alarm_o);
    // R7: an alarm follows an offered sample
    a_r7_alarm_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |-> $past(smp_valid));
    // R8: failure follows an offered sample
    a_r8_fail_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_o) |-> $past(smp_valid));
endmodule

// File: tb/test_ehm_health_monitor.sv
module test_ehm_health_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int SW  = 4;
    localparam int WIN = 16;
    localparam int CW  = $clog2(WIN) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic [CW-1:0] rep_cutoff = CW'(15);
    logic          rep_is_fatal = 1'b0;
    logic [CW-1:0] prop_cutoff = CW'(15);
    logic          prop_is_fatal = 1'b0;
    logic          alarm_o, fail_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ehm_health_monitor #(.SAMPLE_W(SW), .WIN_LEN(WIN)) i_ehm_health_monitor (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .rep_cutoff(rep_cutoff), .rep_is_fatal(rep_is_fatal),
        .prop_cutoff(prop_cutoff), .prop_is_fatal(prop_is_fatal),
        .alarm_o(alarm_o), .fail_o(fail_o));

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // one accepted-sample cycle; outputs read just after the edge
    task automatic push(input logic [SW-1:0] d, output logic a, output logic f);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = d;
        @(posedge clk);
        #1;
        a = alarm_o;
        f = fail_o;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input logic [SW-1:0] d, output logic a);
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = d;
        @(posedge clk);
        #1;
        a = alarm_o;
    endtask

    task automatic do_reset(input int rc, input logic rf, input int pc, input logic pf);
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        rep_cutoff = CW'(rc);
        rep_is_fatal = rf;
        prop_cutoff = CW'(pc);
        prop_is_fatal = pf;
        repeat (2) @(posedge clk);
        #1;
        check("R1 alarm in reset", alarm_o, 1'b0);
        check("R1 fail in reset", fail_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_run_basic();
        logic a, f;
        do_reset(4, 1'b0, 15, 1'b1);
        for (int i = 0; i < 3; i++) begin
            push(4'hA, a, f);
            check("R3 no alarm below cutoff", a, 1'b0);
        end
        push(4'hA, a, f);
        check("R3 alarm at run cutoff", a, 1'b1);
        check("R7 non-fatal gives no fail", f, 1'b0);
        idle(4'hA, a);
        check("R7 alarm one cycle", a, 1'b0);
        for (int i = 0; i < 3; i++) begin
            push(4'hA, a, f);
            check("R4 run restarted after hit", a, 1'b0);
        end
        push(4'hA, a, f);
        check("R4 second hit after full run", a, 1'b1);
    endtask

    task automatic t_run_break();
        logic a, f;
        do_reset(4, 1'b0, 15, 1'b0);
        push(4'h3, a, f); push(4'h3, a, f); push(4'h3, a, f);
        check("R3 three equal no alarm", a, 1'b0);
        push(4'h5, a, f);
        check("R3 differing sample restarts", a, 1'b0);
        push(4'h5, a, f); push(4'h5, a, f);
        check("R3 run of three no alarm", a, 1'b0);
        push(4'h5, a, f);
        check("R3 alarm after restarted run", a, 1'b1);
    endtask

    task automatic t_valid_gap();
        logic a, f;
        do_reset(3, 1'b0, 15, 1'b0);
        push(4'h7, a, f); push(4'h7, a, f);
        for (int i = 0; i < 4; i++) begin
            idle(4'h2, a);
            check("R2 unaccepted data ignored", a, 1'b0);
        end
        push(4'h7, a, f);
        check("R2 run survives invalid cycles", a, 1'b1);
    endtask

    task automatic t_window();
        logic a, f;
        do_reset(15, 1'b0, 5, 1'b0);
        // window 1: reference 9, three more matches (total 4)
        push(4'h9, a, f);
        for (int i = 1; i < WIN; i++) begin
            push((i == 3 || i == 5 || i == 7) ? 4'h9 : ((i % 2) ? 4'h1 : 4'h2), a, f);
            check("R5 four matches stay quiet", a, 1'b0);
        end
        // window 2: reference 6, 9 no longer counts
        push(4'h6, a, f);
        check("R5 new window reference", a, 1'b0);
        for (int i = 0; i < 3; i++) begin
            push(4'h9, a, f);
            check("R5 old reference not counted", a, 1'b0);
            push(4'h6, a, f);
            check("R6 below match cutoff", a, 1'b0);
        end
        push(4'h9, a, f);
        push(4'h6, a, f);
        check("R6 alarm at match cutoff", a, 1'b1);
        push(4'h9, a, f);
        push(4'h6, a, f);
        check("R6 only one hit per window", a, 1'b0);
    endtask

    task automatic t_rep_fatal();
        logic a, f;
        do_reset(3, 1'b1, 15, 1'b0);
        push(4'hC, a, f); push(4'hC, a, f);
        check("R8 no fail below cutoff", f, 1'b0);
        push(4'hC, a, f);
        check("R8 fail at fatal run hit", f, 1'b1);
        check("R8 no alarm with fail", a, 1'b0);
        for (int i = 0; i < 6; i++) push(4'hC, a, f);
        check("R8 fail sticky", f, 1'b1);
        check("R8 alarm stays low when dead", a, 1'b0);
        do_reset(3, 1'b0, 15, 1'b0);
        #1;
        check("R1 reset clears fail", fail_o, 1'b0);
    endtask

    task automatic t_prop_fatal();
        logic a, f;
        do_reset(15, 1'b0, 3, 1'b1);
        push(4'h4, a, f); push(4'h8, a, f); push(4'h4, a, f); push(4'h8, a, f);
        check("R8 no fail below match cutoff", f, 1'b0);
        push(4'h4, a, f);
        check("R8 fail at fatal window hit", f, 1'b1);
        check("R8 no alarm on fatal hit", a, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_run_basic();
        t_run_break();
        t_valid_gap();
        t_window();
        t_rep_fatal();
        t_prop_fatal();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule